// File: doc/BRIEF.md
# Single-Request Interrupt Concentrator

This block gathers sixty-four level-sensitive interrupt lines and hands the processor no more than one request at a time, as a vector number with a valid level and a one-cycle load strobe. Lines 0 to 31 belong to expansion-bus slots and lines 32 to 63 to on-board peripherals. Each slot line is gated by an enable bit shared with three neighbours in a group of four. Each on-board line has an enable bit of its own.

Software reaches the block through a 32-bit register port. It uses mapping registers to turn groups and lines on or off, and clear registers to acknowledge the request being served. Once a request is loaded it stays presented until software acknowledges it or disables its owner. The one exception is a newly rising, enabled slot line, which takes the place of the current request. A small combinational helper also converts a slot number, a function parity bit and an interrupt pin into the slot line number.

Top module: `irq_single_req`

## Requirements
- R1: After reset no request is presented, every enable bit is zero, and mapping registers read back their fixed low bits: slot group g reads 0x7C0 + 4*g and on-board line j reads 0x7E0 + j.
- R2: A mapping register write stores only wdata bit 31 as the enable. A read returns that enable in bit 31 over the fixed low bits. Slot group g sits at 0x0C04 + 8*g and on-board line j at 0x1004 + 8*j.
- R3: Register space answers only when address bit 2 is 1. Reads with bit 2 clear return zero, and writes with bit 2 clear change nothing.
- R4: With no request outstanding, the block picks the lowest-numbered line that is high and enabled. Slot lines 0-31 therefore win over on-board lines 32-63. Slot line n is enabled by group n/4, and on-board line n by entry n-32.
- R5: The request output is registered. A choice made from the inputs and writes seen at one rising edge appears after that edge. req_stb is high for exactly one cycle each time the request register is loaded, and only while req_vld is high.
- R6: An outstanding request keeps its number while it is not acknowledged or disabled. This holds even if its line falls or an enabled on-board line rises.
- R7: An enabled slot line that rises while a request is outstanding replaces the current request, and req_stb pulses.
- R8: Writing a zero enable to the mapping register that owns the current request drops it, and a new scan runs in the same cycle.
- R9: A write to 0x1404 + 32*g acknowledges the current request when its number divided by 4 equals g, and a new scan runs at once. A still-high line is therefore presented again.
- R10: A write to 0x1804 + 8*j acknowledges the current request only when it equals 32 + j, followed by a new scan. Any other index changes nothing.
- R11: map_line equals (16 when map_fn_odd is 1, else 0) + 4*map_slot + map_pin, truncated to 5 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lvl | input | 64 | Interrupt line levels, bit n is line n |
| reg_wr | input | 1 | Register write strobe for one cycle |
| reg_addr | input | 16 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| req_vld | output | 1 | A request is being presented |
| req_vec | output | 6 | Number of the presented line |
| req_stb | output | 1 | One-cycle pulse when the request register is loaded |
| map_slot | input | 5 | Slot number for line mapping |
| map_fn_odd | input | 1 | Low bit of the function number |
| map_pin | input | 2 | Interrupt pin, 0 to 3 |
| map_line | output | 5 | Slot line number |

## Verification
The properties assume that irq_lvl, reg_wr, reg_addr and reg_wdata are steady around each rising edge. They also assume that a write strobe lasts one cycle, so at most one register event reaches the arbiter per edge. The hold property further assumes that, without a write and without a newly rising enabled slot line, nothing else may move the request. The bench changes every input on the falling edge, pulses reg_wr for a single cycle per task call and never overlaps a write with a line change, so each scenario meets these assumptions.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   localparam int unsigned REG_W  = 32;
   localparam int unsigned EN_BIT = 31;

   typedef enum logic [1:0] {
      RG_PCI_MAP = 2'd0,
      RG_OB_MAP  = 2'd1,
      RG_PCI_CLR = 2'd2,
      RG_OB_CLR  = 2'd3
   } rgn_e;

   typedef struct packed {
      logic       vld;
      rgn_e       rgn;
      logic [4:0] idx;
      logic       en;
   } wr_evt_t;

   function automatic logic [30:0] pci_map_init(input logic [31:0] g);
      logic [31:0] v;
      v = (32'h1F << 6) | (g << 2);
      return v[30:0];
   endfunction

   function automatic logic [30:0] ob_map_init(input logic [31:0] j);
      logic [31:0] v;
      v = ((32'h1F << 6) | 32'h20) + j;
      return v[30:0];
   endfunction

endpackage

// File: rtl/irqc_lowpick.sv
module irqc_lowpick #(
   parameter int unsigned W     = 64,
   parameter int unsigned IDX_W = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]     vec,
   output logic             hit,
   output logic [IDX_W-1:0] idx
);

   always_comb begin
      hit = |vec;
      idx = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
   import irqc_pkg::*;
#(
   parameter int unsigned NUM_GRP    = 8,
   parameter int unsigned PER_GRP    = 4,
   parameter int unsigned NUM_OB     = 32,
   parameter int unsigned ADDR_W     = 16,
   parameter logic [7:0]  PG_PCI_MAP = 8'h0C,
   parameter logic [7:0]  PG_OB_MAP  = 8'h10,
   parameter logic [7:0]  PG_PCI_CLR = 8'h14,
   parameter logic [7:0]  PG_OB_CLR  = 8'h18,
   localparam int unsigned NUM_PCI   = NUM_GRP * PER_GRP,
   localparam int unsigned NUM_LINES = NUM_PCI + NUM_OB
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [REG_W-1:0]     reg_wdata,
   output logic [REG_W-1:0]     reg_rdata,
   output wr_evt_t              evt,
   output logic [NUM_LINES-1:0] line_en_q,
   output logic [NUM_LINES-1:0] line_en_nxt
);

   logic [NUM_GRP-1:0] pci_en_q, pci_en_nxt;
   logic [NUM_OB-1:0]  ob_en_q,  ob_en_nxt;

   logic       hi_ok;
   logic [7:0] page;
   logic       odd;
   logic [2:0] g_map;
   logic [2:0] g_clr;
   logic [4:0] j_idx;
   logic       g_map_ok, g_clr_ok, j_ok;
   logic       hit_pci_map, hit_ob_map, hit_pci_clr, hit_ob_clr;
   logic       unused_bits;

   assign page  = reg_addr[15:8];
   assign odd   = reg_addr[2];
   assign g_map = reg_addr[5:3];
   assign g_clr = reg_addr[7:5];
   assign j_idx = reg_addr[7:3];

   assign unused_bits = ^{reg_addr[1:0], reg_wdata[EN_BIT-1:0]};

   // upper address bits beyond the 64 KiB window must be zero
   if (ADDR_W > 16) begin : g_hi
      assign hi_ok = ~|reg_addr[ADDR_W-1:16];
   end else begin : g_nohi
      assign hi_ok = 1'b1;
   end

   // index range checks, trivial when the array fills its index field
   if (NUM_GRP == 8) begin : g_grp_full
      assign g_map_ok = 1'b1;
      assign g_clr_ok = 1'b1;
   end else begin : g_grp_part
      assign g_map_ok = (32'(g_map) < NUM_GRP);
      assign g_clr_ok = (32'(g_clr) < NUM_GRP);
   end

   if (NUM_OB == 32) begin : g_ob_full
      assign j_ok = 1'b1;
   end else begin : g_ob_part
      assign j_ok = (32'(j_idx) < NUM_OB);
   end

   assign hit_pci_map = hi_ok && odd && (page == PG_PCI_MAP)
                        && (reg_addr[7:6] == 2'b00) && g_map_ok;
   assign hit_ob_map  = hi_ok && odd && (page == PG_OB_MAP)  && j_ok;
   assign hit_pci_clr = hi_ok && odd && (page == PG_PCI_CLR) && g_clr_ok;
   assign hit_ob_clr  = hi_ok && odd && (page == PG_OB_CLR)  && j_ok;

   // enable storage: only bit 31 of a mapping write is kept
   always_comb begin
      pci_en_nxt = pci_en_q;
      ob_en_nxt  = ob_en_q;
      if (reg_wr && hit_pci_map) pci_en_nxt[g_map] = reg_wdata[EN_BIT];
      if (reg_wr && hit_ob_map)  ob_en_nxt[j_idx]  = reg_wdata[EN_BIT];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pci_en_q <= '0;
         ob_en_q  <= '0;
      end else begin
         pci_en_q <= pci_en_nxt;
         ob_en_q  <= ob_en_nxt;
      end
   end

   // event toward the arbiter
   always_comb begin
      evt     = '0;
      evt.en  = reg_wdata[EN_BIT];
      evt.idx = j_idx;
      if (reg_wr) begin
         if (hit_pci_map) begin
            evt.vld = 1'b1;
            evt.rgn = RG_PCI_MAP;
            evt.idx = {2'b00, g_map};
         end else if (hit_ob_map) begin
            evt.vld = 1'b1;
            evt.rgn = RG_OB_MAP;
         end else if (hit_pci_clr) begin
            evt.vld = 1'b1;
            evt.rgn = RG_PCI_CLR;
            evt.idx = {2'b00, g_clr};
         end else if (hit_ob_clr) begin
            evt.vld = 1'b1;
            evt.rgn = RG_OB_CLR;
         end
      end
   end

   // read path: low bits are fixed, so they are computed, not stored
   always_comb begin
      reg_rdata = '0;
      if (hit_pci_map)
         reg_rdata = {pci_en_q[g_map], pci_map_init(32'(g_map))};
      else if (hit_ob_map)
         reg_rdata = {ob_en_q[j_idx], ob_map_init(32'(j_idx))};
   end

   // per-line enable expansion
   for (genvar l = 0; l < NUM_PCI; l++) begin : g_pci_line
      assign line_en_q[l]   = pci_en_q[l / PER_GRP];
      assign line_en_nxt[l] = pci_en_nxt[l / PER_GRP];
   end
   for (genvar l = 0; l < NUM_OB; l++) begin : g_ob_line
      assign line_en_q[NUM_PCI + l]   = ob_en_q[l];
      assign line_en_nxt[NUM_PCI + l] = ob_en_nxt[l];
   end

endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
   import irqc_pkg::*;
#(
   parameter int unsigned NUM_GRP    = 8,
   parameter int unsigned PER_GRP    = 4,
   parameter int unsigned NUM_OB     = 32,
   localparam int unsigned NUM_PCI   = NUM_GRP * PER_GRP,
   localparam int unsigned NUM_LINES = NUM_PCI + NUM_OB,
   localparam int unsigned VEC_W     = $clog2(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_lvl,
   input  logic [NUM_LINES-1:0] line_en_nxt,
   input  wr_evt_t              evt,
   output logic [NUM_LINES-1:0] in_q,
   output logic                 req_vld,
   output logic [VEC_W-1:0]     req_vec,
   output logic                 req_stb
);

   localparam logic [NUM_LINES-1:0] PCI_MASK =
      {{NUM_OB{1'b0}}, {NUM_PCI{1'b1}}};

   logic [NUM_LINES-1:0] cand, pre;
   logic                 scan_hit, pre_hit;
   logic [VEC_W-1:0]     scan_idx, pre_idx;
   logic [31:0]          req_n, ev_i;
   logic                 req_is_pci;
   logic                 drop;
   logic                 nxt_vld, load;
   logic [VEC_W-1:0]     nxt_vec;

   // latched input vector, used for edge detection on slot lines
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) in_q <= '0;
      else        in_q <= irq_lvl;
   end

   assign cand = irq_lvl & line_en_nxt;
   assign pre  = irq_lvl & ~in_q & line_en_nxt & PCI_MASK;

   irqc_lowpick #(.W(NUM_LINES), .IDX_W(VEC_W)) u_scan (
      .vec (cand),
      .hit (scan_hit),
      .idx (scan_idx)
   );

   irqc_lowpick #(.W(NUM_LINES), .IDX_W(VEC_W)) u_pre (
      .vec (pre),
      .hit (pre_hit),
      .idx (pre_idx)
   );

   assign req_n      = 32'(req_vec);
   assign ev_i       = 32'(evt.idx);
   assign req_is_pci = (req_n < NUM_PCI);

   // drop decision: owner disabled or acknowledged
   always_comb begin
      drop = 1'b0;
      if (req_vld && evt.vld) begin
         case (evt.rgn)
            RG_PCI_MAP: drop = req_is_pci && !evt.en
                               && ((req_n / PER_GRP) == ev_i);
            RG_OB_MAP:  drop = !req_is_pci && !evt.en
                               && ((req_n - NUM_PCI) == ev_i);
            RG_PCI_CLR: drop = req_is_pci && ((req_n / PER_GRP) == ev_i);
            RG_OB_CLR:  drop = !req_is_pci && ((req_n - NUM_PCI) == ev_i);
            default:    drop = 1'b0;
         endcase
      end
   end

   // next request: rescan when idle or dropped, else hold or pre-empt
   always_comb begin
      nxt_vld = req_vld;
      nxt_vec = req_vec;
      load    = 1'b0;
      if (!req_vld || drop) begin
         nxt_vld = scan_hit;
         nxt_vec = scan_hit ? scan_idx : '0;
         load    = scan_hit;
      end else if (pre_hit) begin
         nxt_vec = pre_idx;
         load    = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_vld <= 1'b0;
         req_vec <= '0;
         req_stb <= 1'b0;
      end else begin
         req_vld <= nxt_vld;
         req_vec <= nxt_vec;
         req_stb <= load;
      end
   end

endmodule

// File: rtl/irqc_linemap.sv
module irqc_linemap #(
   parameter int unsigned SLOT_W = 5,
   parameter int unsigned LINE_W = 5
) (
   input  logic [SLOT_W-1:0] slot,
   input  logic              fn_odd,
   input  logic [1:0]        pin,
   output logic [LINE_W-1:0] line
);

   logic [SLOT_W+4:0] sum;
   logic              unused_hi;

   assign sum = ({5'b0, slot} << 2)
              + (fn_odd ? (SLOT_W+5)'(16) : '0)
              + (SLOT_W+5)'(pin);

   assign line      = sum[LINE_W-1:0];
   assign unused_hi = ^sum[SLOT_W+4:LINE_W];

endmodule

// File: rtl/irq_single_req.sv
module irq_single_req
   import irqc_pkg::*;
#(
   parameter int unsigned NUM_GRP = 8,
   parameter int unsigned PER_GRP = 4,
   parameter int unsigned NUM_OB  = 32,
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned SLOT_W  = 5
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic [NUM_GRP*PER_GRP+NUM_OB-1:0]       irq_lvl,
   input  logic                                    reg_wr,
   input  logic [ADDR_W-1:0]                       reg_addr,
   input  logic [REG_W-1:0]                        reg_wdata,
   output logic [REG_W-1:0]                        reg_rdata,
   output logic                                    req_vld,
   output logic [$clog2(NUM_GRP*PER_GRP+NUM_OB)-1:0] req_vec,
   output logic                                    req_stb,
   input  logic [SLOT_W-1:0]                       map_slot,
   input  logic                                    map_fn_odd,
   input  logic [1:0]                              map_pin,
   output logic [4:0]                              map_line
);

   localparam int unsigned NUM_PCI   = NUM_GRP * PER_GRP;
   localparam int unsigned NUM_LINES = NUM_PCI + NUM_OB;
   localparam int unsigned VEC_W     = $clog2(NUM_LINES);

   // elaboration-time parameter checks
   if (NUM_GRP < 1 || NUM_GRP > 8) begin : g_bad_grp
      $error("NUM_GRP must be 1..8");
   end
   if (PER_GRP < 1 || NUM_PCI > 32) begin : g_bad_per
      $error("NUM_GRP*PER_GRP must be 1..32");
   end
   if (NUM_OB < 1 || NUM_OB > 32) begin : g_bad_ob
      $error("NUM_OB must be 1..32");
   end
   if (ADDR_W < 16) begin : g_bad_aw
      $error("ADDR_W must be at least 16");
   end
   if (SLOT_W < 3) begin : g_bad_slot
      $error("SLOT_W must be at least 3");
   end

   wr_evt_t              evt;
   logic [NUM_LINES-1:0] line_en_q;
   logic [NUM_LINES-1:0] line_en_nxt;
   logic [NUM_LINES-1:0] in_q;

   irqc_regs #(
      .NUM_GRP (NUM_GRP),
      .PER_GRP (PER_GRP),
      .NUM_OB  (NUM_OB),
      .ADDR_W  (ADDR_W)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_wr      (reg_wr),
      .reg_addr    (reg_addr),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .evt         (evt),
      .line_en_q   (line_en_q),
      .line_en_nxt (line_en_nxt)
   );

   irqc_arb #(
      .NUM_GRP (NUM_GRP),
      .PER_GRP (PER_GRP),
      .NUM_OB  (NUM_OB)
   ) u_arb (
      .clk         (clk),
      .rst_n       (rst_n),
      .irq_lvl     (irq_lvl),
      .line_en_nxt (line_en_nxt),
      .evt         (evt),
      .in_q        (in_q),
      .req_vld     (req_vld),
      .req_vec     (req_vec),
      .req_stb     (req_stb)
   );

   irqc_linemap #(
      .SLOT_W (SLOT_W),
      .LINE_W (5)
   ) u_linemap (
      .slot   (map_slot),
      .fn_odd (map_fn_odd),
      .pin    (map_pin),
      .line   (map_line)
   );

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
   parameter int unsigned NUM_LINES = 64,
   parameter int unsigned NUM_PCI   = 32,
   parameter int unsigned VEC_W     = 6
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] irq_lvl,
   input logic [NUM_LINES-1:0] in_q,
   input logic [NUM_LINES-1:0] line_en_q,
   input logic                 reg_wr,
   input logic                 addr_odd,
   input logic [31:0]          reg_rdata,
   input logic                 req_vld,
   input logic [VEC_W-1:0]     req_vec,
   input logic                 req_stb
);

   localparam logic [NUM_LINES-1:0] PCI_MASK =
      {{(NUM_LINES-NUM_PCI){1'b0}}, {NUM_PCI{1'b1}}};

   logic [NUM_LINES-1:0] lowmask;
   logic [NUM_LINES-1:0] pci_rise_en;

   assign lowmask     = (NUM_LINES'(1) << req_vec) - NUM_LINES'(1);
   assign pci_rise_en = irq_lvl & ~in_q & line_en_q & PCI_MASK;

   // R1: leaving reset, nothing is presented
   p_idle_out_of_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !req_vld);

   // R3: even words read as zero
   p_even_word_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_odd |-> (reg_rdata == 32'h0));

   // R5: the strobe only accompanies a valid request
   p_stb_with_vld_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_stb |-> req_vld);

   // R4: a loaded request names an enabled line that was high
   p_pick_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_stb |-> (line_en_q[req_vec] && ((($past(irq_lvl) >> req_vec) & NUM_LINES'(1)) != '0)));

   // R4: a fresh scan takes the lowest enabled active line
   p_lowest_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_stb && !$past(req_vld)) |-> (($past(irq_lvl) & line_en_q & lowmask) == '0));

   // R6: no write and no enabled slot-line rise means the request holds
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && !reg_wr && (pci_rise_en == '0)) |=> (req_vld && $stable(req_vec)));

endmodule

bind irq_single_req irqc_checker #(
   .NUM_LINES (NUM_LINES),
   .NUM_PCI   (NUM_PCI),
   .VEC_W     (VEC_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_lvl   (irq_lvl),
   .in_q      (in_q),
   .line_en_q (line_en_q),
   .reg_wr    (reg_wr),
   .addr_odd  (reg_addr[2]),
   .reg_rdata (reg_rdata),
   .req_vld   (req_vld),
   .req_vec   (req_vec),
   .req_stb   (req_stb)
);

// File: tb/tb_irq_single_req.sv
module tb_irq_single_req;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] irq_lvl = '0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_addr = 16'h0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        req_vld;
   logic [5:0]  req_vec;
   logic        req_stb;
   logic [4:0]  map_slot = '0;
   logic        map_fn_odd = 1'b0;
   logic [1:0]  map_pin = '0;
   logic [4:0]  map_line;

   int n_chk  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;   // 125 MHz

   irq_single_req dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_lvl    (irq_lvl),
      .reg_wr     (reg_wr),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .req_vld    (req_vld),
      .req_vec    (req_vec),
      .req_stb    (req_stb),
      .map_slot   (map_slot),
      .map_fn_odd (map_fn_odd),
      .map_pin    (map_pin),
      .map_line   (map_line)
   );

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      $display("FAIL watchdog: run did not complete");
      n_fail++;
      finish_run();
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic chk_req(input string req, input logic vld, input logic [5:0] vec, input logic stb);
      chk({req, " vld"}, 32'(req_vld), 32'(vld));
      if (vld) chk({req, " vec"}, 32'(req_vec), 32'(vec));
      chk({req, " stb"}, 32'(req_stb), 32'(stb));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = 16'h0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
      reg_addr = 16'h0;
   endtask

   task automatic set_line(input int n, input logic v);
      @(negedge clk);
      irq_lvl[n] = v;
      @(negedge clk);
   endtask

   function automatic logic [15:0] a_pmap(input int g);  return 16'(32'h0C04 + 8 * g);  endfunction
   function automatic logic [15:0] a_omap(input int j);  return 16'(32'h1004 + 8 * j);  endfunction
   function automatic logic [15:0] a_pclr(input int g);  return 16'(32'h1404 + 32 * g); endfunction
   function automatic logic [15:0] a_oclr(input int j);  return 16'(32'h1804 + 8 * j);  endfunction

   task automatic t_reset_state();
      logic [31:0] d;
      irq_lvl = '0;
      do_reset();
      @(negedge clk);
      chk_req("R1 idle", 1'b0, 6'd0, 1'b0);
      rd(a_pmap(3), d);  chk("R1 slot map 3", d, 32'h0000_07CC);
      rd(a_omap(5), d);  chk("R1 board map 5", d, 32'h0000_07E5);
   endtask

   task automatic t_map_rw();
      logic [31:0] d;
      do_reset();
      wr(a_pmap(2), 32'hFFFF_FFFF);
      rd(a_pmap(2), d);  chk("R2 slot map only bit31", d, 32'h8000_07C8);
      wr(a_pmap(2), 32'h0000_0000);
      rd(a_pmap(2), d);  chk("R2 slot map disable", d, 32'h0000_07C8);
      wr(16'h0C10, 32'hFFFF_FFFF);
      rd(a_pmap(2), d);  chk("R3 even write ignored", d, 32'h0000_07C8);
      rd(16'h0C10, d);   chk("R3 even read zero", d, 32'h0);
      wr(a_omap(31), 32'h8000_0000);
      rd(a_omap(31), d); chk("R2 board map 31", d, 32'h8000_07FF);
   endtask

   task automatic t_scan_hold_preempt();
      do_reset();
      @(negedge clk);
      irq_lvl[2] = 1'b1; irq_lvl[6] = 1'b1; irq_lvl[35] = 1'b1;
      @(negedge clk);
      chk_req("R4 nothing enabled", 1'b0, 6'd0, 1'b0);
      wr(a_omap(3), 32'h8000_0000);
      chk_req("R4 board line 35 alone", 1'b1, 6'd35, 1'b1);
      wr(a_omap(3), 32'h0000_0000);
      chk_req("R8 board disable drops", 1'b0, 6'd0, 1'b0);
      wr(a_pmap(1), 32'h8000_0000);
      chk_req("R5 slot line 6 loaded", 1'b1, 6'd6, 1'b1);
      @(negedge clk);
      chk_req("R5 strobe one cycle", 1'b1, 6'd6, 1'b0);
      wr(a_omap(3), 32'h8000_0000);
      chk_req("R6 hold after enable", 1'b1, 6'd6, 1'b0);
      set_line(6, 1'b0);
      chk_req("R6 hold after line falls", 1'b1, 6'd6, 1'b0);
      wr(a_omap(4), 32'h8000_0000);
      set_line(36, 1'b1);
      chk_req("R6 board rise no preempt", 1'b1, 6'd6, 1'b0);
      set_line(5, 1'b1);
      chk_req("R7 slot rise preempts", 1'b1, 6'd5, 1'b1);
   endtask

   task automatic t_disable_and_board_clear();
      // continues from t_scan_hold_preempt: lines 2,5,35,36 high; grp1, ob3, ob4 on
      wr(a_pmap(1), 32'h0000_0000);
      chk_req("R8 owner disable rescans", 1'b1, 6'd35, 1'b1);
      wr(a_oclr(4), 32'h0);
      chk_req("R10 other index ignored", 1'b1, 6'd35, 1'b0);
      wr(a_oclr(3), 32'h0);
      chk_req("R10 exact match resubmits", 1'b1, 6'd35, 1'b1);
      set_line(35, 1'b0);
      wr(a_oclr(3), 32'h0);
      chk_req("R10 clear moves to 36", 1'b1, 6'd36, 1'b1);
      wr(a_omap(4), 32'h0000_0000);
      chk_req("R8 disable leaves idle", 1'b0, 6'd0, 1'b0);
   endtask

   task automatic t_slot_clear();
      irq_lvl = '0;
      do_reset();
      wr(a_pmap(2), 32'h8000_0000);
      @(negedge clk);
      irq_lvl[8] = 1'b1; irq_lvl[11] = 1'b1;
      @(negedge clk);
      chk_req("R4 group shares enable, lowest first", 1'b1, 6'd8, 1'b1);
      wr(a_pclr(3), 32'h0);
      chk_req("R9 other group ignored", 1'b1, 6'd8, 1'b0);
      wr(16'h1440, 32'h0);
      chk_req("R3 even clear ignored", 1'b1, 6'd8, 1'b0);
      wr(a_pclr(2), 32'h0);
      chk_req("R9 clear resubmits high line", 1'b1, 6'd8, 1'b1);
      set_line(8, 1'b0);
      wr(a_pclr(2), 32'h0);
      chk_req("R9 clear moves within group", 1'b1, 6'd11, 1'b1);
      set_line(11, 1'b0);
      wr(a_pclr(2), 32'h0);
      chk_req("R9 clear leaves idle", 1'b0, 6'd0, 1'b0);
   endtask

   task automatic t_reset_midflight();
      logic [31:0] d;
      irq_lvl = '0;
      do_reset();
      wr(a_pmap(0), 32'h8000_0000);
      set_line(0, 1'b1);
      chk_req("R4 line 0", 1'b1, 6'd0, 1'b1);
      do_reset();
      @(negedge clk);
      chk_req("R1 reset drops request", 1'b0, 6'd0, 1'b0);
      rd(a_pmap(0), d); chk("R1 reset clears enable", d, 32'h0000_07C0);
      irq_lvl = '0;
   endtask

   task automatic t_linemap();
      @(negedge clk);
      map_slot = 5'd3; map_fn_odd = 1'b1; map_pin = 2'd2;
      #1 chk("R11 slot3 odd pin2", 32'(map_line), 32'd30);
      map_slot = 5'd5; map_fn_odd = 1'b0; map_pin = 2'd1;
      #1 chk("R11 slot5 even pin1", 32'(map_line), 32'd21);
      map_slot = 5'd7; map_fn_odd = 1'b1; map_pin = 2'd3;
      #1 chk("R11 slot7 odd pin3 wraps", 32'(map_line), 32'd15);
   endtask

   initial begin
      t_reset_state();
      t_map_rw();
      t_scan_hold_preempt();
      t_disable_and_board_clear();
      t_slot_clear();
      t_reset_midflight();
      t_linemap();
      finish_run();
   end

endmodule